// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block guards a processor against a software hang. It counts strobes from a slow 16 Hz time base that arrives as a one-cycle pulse on `tick_i`. Software sets the timeout through a byte-wide watchdog register. That register holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. Software keeps the watchdog quiet by either rewriting that register or reading the flags register, and each of these restarts the countdown.

When the countdown runs out, the block records a timeout flag. The steering bit then decides what happens. With steering set, the block raises a one-cycle system reset request, wipes the watchdog register and clears bit 6 of a companion control byte. With steering clear, it pulses an interrupt for one cycle and leaves the configuration in place. After a timeout the countdown stays idle until software restarts it.

The host reaches three byte registers through a 2-bit select:
- 0: watchdog configuration.
- 1: flags, read-only.
- 2: control byte.
- 3: reads as zero.

Read data is combinational from the select.

Top module: `wdt_steer`

## Requirements
- R1: After reset, all three registers read 0x00 and both `rst_req_o` and `irq_o` are low.
- R2: Watchdog register bits 6:2 are the multiplier M and bits 1:0 the resolution code C. The timeout fires on the (M << 2C)-th `tick_i` pulse seen after the restart. This gives steps of 1, 4, 16 or 64 ticks.
- R3: A write to select 0 stores the byte, clears flag bit 7 and restarts the countdown with the new value.
- R4: A read strobe (`rd_en_i`) on select 1 restarts the countdown from the current watchdog value without changing it.
- R5: On a timeout, flag bit 7 is set, so select 1 reads 0x80.
- R6: A timeout with watchdog bit 7 set drives `rst_req_o` high for exactly one cycle. It also clears the watchdog register to 0x00, clears bit 6 of the control byte, and keeps `irq_o` low.
- R7: A timeout with watchdog bit 7 clear drives `irq_o` high for exactly one cycle. The watchdog register keeps its value and `rst_req_o` stays low.
- R8: Writes to select 1 have no effect on the flags.
- R9: A multiplier of zero disables the countdown, so no timeout ever occurs.
- R10: After a timeout no further timeout occurs until a restart.
- R11: A restart in the same cycle as the final tick wins: no timeout happens that cycle, and the new countdown starts from its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe from the 16 Hz time base |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe (needed for the flags-read restart) |
| addr_i | input | 2 | Register select: 0 watchdog, 1 flags, 2 control |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for the selected register |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle watchdog interrupt |

## Verification
The properties assume the following about the inputs:
- `tick_i` is a single-cycle strobe.
- Each host access is a strobe sampled at one clock edge.
- A register write never coincides with a reset release.

The stimulus issues a tick every fifth clock and performs one access at a time, each held for exactly one edge. The one deliberate collision is a watchdog rewrite placed on the cycle of the final tick. It checks that a restart overrides an expiry.

// File: rtl/wdt_steer_pkg.sv
`timescale 1ns/1ps
package wdt_steer_pkg;

   typedef enum logic [1:0] {
      SEL_WD    = 2'd0,
      SEL_FLAGS = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_SPARE = 2'd3
   } wdt_sel_e;

   // longest countdown in ticks needs the multiplier plus the largest shift
   function automatic int span_width(input int mult_w, input int res_w);
      return mult_w + 2 * ((1 << res_w) - 1);
   endfunction

endpackage

// File: rtl/wdt_span_calc.sv
`timescale 1ns/1ps
module wdt_span_calc #(
   parameter int MULT_W    = 5,
   parameter int RES_W     = 2,
   parameter int CNT_W     = 11,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [MULT_W-1:0] mult_i,
   input  logic [RES_W-1:0]  res_i,
   output logic [CNT_W-1:0]  span_o
);
   localparam int NRES = 1 << RES_W;

   generate
      if (USE_TABLE) begin : g_table
         logic [CNT_W-1:0] opts [NRES];
         for (genvar r = 0; r < NRES; r++) begin : g_opt
            assign opts[r] = CNT_W'(mult_i) << (2 * r);
         end
         assign span_o = opts[res_i];
      end else begin : g_shift
         assign span_o = CNT_W'(mult_i) << {res_i, 1'b0};
      end
   endgenerate

endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
   parameter int CNT_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             tick_i,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   // a restart in the same cycle masks the final tick
   assign expire_o = tick_i & armed_q & ~restart_i & (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (restart_i) begin
         cnt_q   <= load_i;
         armed_q <= |load_i;
      end else if (tick_i && armed_q) begin
         cnt_q <= cnt_q - LAST;
         if (cnt_q == LAST) armed_q <= 1'b0;
      end
   end

endmodule

// File: rtl/wdt_regfile.sv
`timescale 1ns/1ps
module wdt_regfile
   import wdt_steer_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int STEER_BIT = 7,
   parameter int FLAG_BIT  = 7,
   parameter int CLR_BIT   = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              expire_i,
   output logic              restart_o,
   output logic [DATA_W-1:0] cfg_o,
   output logic [DATA_W-1:0] wd_o,
   output logic              flag_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rst_req_o,
   output logic              irq_o
);
   logic [DATA_W-1:0] wd_q, wd_d, ctrl_q, ctrl_d;
   logic              flag_q, flag_d;
   logic              wd_wr, ctrl_wr, flags_rd, steer_hit;

   assign wd_wr     = wr_en_i && (addr_i == SEL_WD);
   assign ctrl_wr   = wr_en_i && (addr_i == SEL_CTRL);
   assign flags_rd  = rd_en_i && (addr_i == SEL_FLAGS);
   assign restart_o = wd_wr | flags_rd;
   assign cfg_o     = wd_wr ? wdata_i : wd_q;
   assign steer_hit = expire_i & wd_q[STEER_BIT];

   always_comb begin
      wd_d   = wd_q;
      flag_d = flag_q;
      ctrl_d = ctrl_q;
      if (wd_wr)         wd_d = wdata_i;
      else if (steer_hit) wd_d = '0;
      if (wd_wr)         flag_d = 1'b0;
      else if (expire_i) flag_d = 1'b1;
      if (ctrl_wr)       ctrl_d = wdata_i;
      if (steer_hit)     ctrl_d[CLR_BIT] = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wd_q      <= '0;
         flag_q    <= 1'b0;
         ctrl_q    <= '0;
         rst_req_o <= 1'b0;
         irq_o     <= 1'b0;
      end else begin
         wd_q      <= wd_d;
         flag_q    <= flag_d;
         ctrl_q    <= ctrl_d;
         rst_req_o <= steer_hit;
         irq_o     <= expire_i & ~wd_q[STEER_BIT];
      end
   end

   always_comb begin
      unique case (addr_i)
         SEL_WD:    rdata_o = wd_q;
         SEL_FLAGS: rdata_o = DATA_W'(flag_q) << FLAG_BIT;
         SEL_CTRL:  rdata_o = ctrl_q;
         default:   rdata_o = '0;
      endcase
   end

   assign wd_o   = wd_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/wdt_steer.sv
`timescale 1ns/1ps
module wdt_steer #(
   parameter int DATA_W    = 8,
   parameter int MULT_W    = 5,
   parameter int RES_W     = 2,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rst_req_o,
   output logic              irq_o
);
   localparam int CNT_W     = wdt_steer_pkg::span_width(MULT_W, RES_W);
   localparam int STEER_BIT = MULT_W + RES_W;
   localparam int FLAG_BIT  = DATA_W - 1;
   localparam int CLR_BIT   = DATA_W - 2;

   generate
      if (STEER_BIT >= DATA_W) begin : g_bad_fields
         $error("watchdog fields do not fit in DATA_W");
      end
      if (DATA_W < 2 || RES_W < 1 || MULT_W < 1) begin : g_bad_sizes
         $error("unsupported watchdog sizes");
      end
   endgenerate

   logic              restart, expire, flag_q;
   logic [DATA_W-1:0] cfg, wd_q;
   logic [CNT_W-1:0]  span;

   wdt_regfile #(
      .DATA_W(DATA_W), .STEER_BIT(STEER_BIT),
      .FLAG_BIT(FLAG_BIT), .CLR_BIT(CLR_BIT)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .expire_i(expire), .restart_o(restart), .cfg_o(cfg),
      .wd_o(wd_q), .flag_o(flag_q), .rdata_o(rdata_o),
      .rst_req_o(rst_req_o), .irq_o(irq_o)
   );

   wdt_span_calc #(
      .MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W), .USE_TABLE(USE_TABLE)
   ) u_span (
      .mult_i(cfg[RES_W +: MULT_W]), .res_i(cfg[RES_W-1:0]), .span_o(span)
   );

   wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
      .load_i(span), .tick_i(tick_i), .expire_o(expire)
   );

endmodule

// File: rtl/wdt_steer_chk.sv
`timescale 1ns/1ps
module wdt_steer_chk #(
   parameter int DATA_W = 8,
   parameter int MULT_W = 5,
   parameter int RES_W  = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [1:0]        addr_i,
   input logic              rst_req_o,
   input logic              irq_o,
   input logic [DATA_W-1:0] wd_q,
   input logic              flag_q
);
   localparam int SB = MULT_W + RES_W;

   p_req_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |=> !rst_req_o);
   p_req_wipes_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> (wd_q == '0) && !irq_o);
   p_irq_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);
   p_irq_keeps_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> !wd_q[SB] && (wd_q[RES_W +: MULT_W] != '0));
   p_flag_on_expiry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_req_o || irq_o) |-> flag_q);
   p_write_clears_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 2'd0) |=> !flag_q);
   p_zero_mult_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wd_q[RES_W +: MULT_W] == '0) |=> !(rst_req_o || irq_o));

endmodule

bind wdt_steer wdt_steer_chk #(.DATA_W(DATA_W), .MULT_W(MULT_W), .RES_W(RES_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
   .rst_req_o(rst_req_o), .irq_o(irq_o), .wd_q(wd_q), .flag_q(flag_q)
);

// File: tb/wdt_steer_tb_top.sv
`timescale 1ns/1ps
module wdt_steer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       rst_req, irq;

   int total = 0, bad = 0, cycles = 0, phase = 0, tick_seen = 0;
   bit tick_on = 1'b1;

   // behavioural reference state
   int   m_cnt = 0;
   bit   m_armed = 0, m_flag = 0, m_req = 0, m_irq = 0;
   logic [7:0] m_wd = 8'h00, m_ctrl = 8'h00;

   always #2.5 clk = ~clk;

   wdt_steer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int span_of(input logic [7:0] v);
      return ((v >> 2) & 31) << (2 * (v & 3));
   endfunction

   function automatic logic [7:0] m_rdata(input logic [1:0] a);
      case (a)
         2'd0: return m_wd;
         2'd1: return m_flag ? 8'h80 : 8'h00;
         2'd2: return m_ctrl;
         default: return 8'h00;
      endcase
   endfunction

   // tick every fifth clock, driven just after the falling edge
   always @(negedge clk) begin
      #1;
      phase = (phase + 1) % 5;
      tick_i = tick_on && (phase == 0);
   end

   // reference model and tick bookkeeping
   always @(posedge clk) begin
      bit restart;
      if (!rst_n) begin
         m_cnt = 0; m_armed = 0; m_flag = 0; m_req = 0; m_irq = 0;
         m_wd = 8'h00; m_ctrl = 8'h00; tick_seen = 0;
      end else begin
         m_req = 0; m_irq = 0;
         restart = (wr_en && addr == 2'd0) || (rd_en && addr == 2'd1);
         if (wr_en && addr == 2'd0) begin m_wd = wdata; m_flag = 0; end
         if (wr_en && addr == 2'd2) m_ctrl = wdata;
         if (restart) begin
            m_cnt = span_of(m_wd); m_armed = (m_cnt != 0); tick_seen = 0;
         end else begin
            if (tick_i) tick_seen++;
            if (tick_i && m_armed) begin
               m_cnt--;
               if (m_cnt == 0) begin
                  m_armed = 0; m_flag = 1;
                  if (m_wd[7]) begin m_req = 1; m_wd = 8'h00; m_ctrl[6] = 1'b0; end
                  else m_irq = 1;
               end
            end
         end
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R6", "rst_req_o", rst_req, m_req);
         check("R7", "irq_o", irq, m_irq);
         check("R3", "rdata_o", rdata, m_rdata(addr));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++; total++;
         $display("FAIL R2 watchdog: cycles=%0d expected below 150000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); #2; wr_en = 1; addr = a; wdata = d;
      @(negedge clk); #2; wr_en = 0;
   endtask

   task automatic bus_read(input logic [1:0] a);
      @(negedge clk); #2; rd_en = 1; addr = a;
      @(negedge clk); #2; rd_en = 0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk); #2; addr = a; #0.2; v = rdata;
   endtask

   task automatic await_event(input int exp_ticks, input bit want_req, input string tag);
      bit got = 0;
      for (int g = 0; g < 3000 && !got; g++) begin
         @(negedge clk);
         if (rst_req || irq) got = 1;
      end
      check(tag, "timeout seen", got, 1);
      check(tag, "ticks to timeout", tick_seen, exp_ticks);
      check(tag, "rst_req_o kind", rst_req, want_req);
      check(tag, "irq_o kind", irq, !want_req);
   endtask

   task automatic quiet(input int n, input string tag);
      int ev = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_req || irq) ev++;
      end
      check(tag, "unexpected timeouts", ev, 0);
   endtask

   initial begin
      logic [7:0] v;
      repeat (4) @(negedge clk);
      #2 rst_n = 1;
      // R1 reset state
      peek(2'd0, v); check("R1", "watchdog reg", v, 0);
      peek(2'd1, v); check("R1", "flags", v, 0);
      peek(2'd2, v); check("R1", "control", v, 0);
      check("R1", "outputs", {rst_req, irq}, 0);

      // R2/R7: M=3, C=0 -> 3 ticks, interrupt steering
      bus_write(2'd0, 8'h0C);
      await_event(3, 0, "R2");
      peek(2'd1, v); check("R5", "flag after timeout", v, 8'h80);
      peek(2'd0, v); check("R7", "config retained", v, 8'h0C);
      // R10: one-shot
      quiet(150, "R10");

      // R8: flags ignore writes while set
      bus_write(2'd1, 8'h00);
      peek(2'd1, v); check("R8", "flags after write 0", v, 8'h80);

      // R3: M=2, C=1 -> 8 ticks, flag cleared by the write
      bus_write(2'd0, 8'h09);
      peek(2'd1, v); check("R3", "flag cleared", v, 8'h00);
      bus_write(2'd1, 8'hFF);
      peek(2'd1, v); check("R8", "flags after write FF", v, 8'h00);
      await_event(8, 0, "R2");

      // R2 coarse resolutions: 16 and 64 ticks
      bus_write(2'd0, 8'h06);
      await_event(16, 0, "R2");
      bus_write(2'd0, 8'h07);
      await_event(64, 0, "R2");

      // R4: reading flags restarts with the current value
      bus_write(2'd0, 8'h0C);
      wait (tick_seen == 2);
      bus_read(2'd1);
      peek(2'd0, v); check("R4", "config unchanged", v, 8'h0C);
      await_event(3, 0, "R4");

      // R9: zero multiplier never times out
      bus_write(2'd0, 8'h03);
      quiet(600, "R9");

      // R6: steered to reset, M=1, C=1 -> 4 ticks
      bus_write(2'd2, 8'hFF);
      bus_write(2'd0, 8'h85);
      await_event(4, 1, "R6");
      peek(2'd0, v); check("R6", "config wiped", v, 8'h00);
      peek(2'd2, v); check("R6", "control bit 6 cleared", v, 8'hBF);
      peek(2'd1, v); check("R6", "flag set", v, 8'h80);
      quiet(100, "R10");

      // R11: rewrite on the cycle of the final tick
      bus_write(2'd0, 8'h08);
      wait (tick_seen == 1);
      do begin @(negedge clk); #2; end while (!tick_i);
      wr_en = 1; addr = 2'd0; wdata = 8'h08;
      @(negedge clk); #2; wr_en = 0;
      check("R11", "no timeout on restart cycle", {rst_req, irq}, 0);
      await_event(2, 0, "R11");

      repeat (10) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule